// File: doc/BRIEF.md
# Conditional Select Adder/Subtractor

This block adds or subtracts two 64-bit operands in a single combinational path. The operand word is cut into eight slices of eight bits each. Every slice works out its eight result bits twice: once as if no carry arrived from below, and once as if a carry did. A separate block-carry network then resolves the true carry into each slice. It uses the same paired generate/propagate carry step that the slices use internally. Each resolved block carry picks one of the two prepared results for its slice.

A single control input chooses the operation. For subtraction the second operand is inverted and a carry of one enters the lowest slice, so the result is the two's-complement difference. The block also reports the carry out of the top bit and a signed overflow flag. There is no clock and no state. The block is meant to sit inside a datapath stage, and a surrounding register boundary captures its outputs.

Top module: `csel_adder`

## Requirements
- R1: With `sub_en` = 0, `result` equals (`opa` + `opb`) mod 2^64 and `carry_out` is the carry out of bit 63.
- R2: With `sub_en` = 1, `result` equals (`opa` − `opb`) mod 2^64. `carry_out` is 1 exactly when `opa` ≥ `opb` as unsigned numbers, so 1 means no borrow.
- R3: `ovf` is 1 exactly when the two's-complement result does not fit in 64 signed bits. For addition this means both operands have the same bit 63 and the result's bit 63 differs from it. For subtraction it means `opa` and `opb` differ in bit 63 and the result's bit 63 differs from `opa`'s.
- R4: A carry produced in bit 0 travels through all eight slice boundaries. All-ones plus one gives zero, with `carry_out` = 1 and `ovf` = 0.
- R5: A carry produced at the top bit of a slice (bits 7, 15, … 55) enters the next slice correctly, including when several slices each hand a carry to their neighbour at the same time.
- R6: Zero operands give a zero result in both modes. The carry out is 0 for addition and 1 for subtraction, and `ovf` is 0 in both modes.
- R7: The block holds no state. Its outputs depend only on the present inputs and stay unchanged across clock edges while the inputs are held.
- R8: Complementary alternating patterns (0xAA…AA with 0x55…55) add to all ones with no carry out. They subtract to the correct wrapped difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 64 | First operand (minuend when subtracting) |
| opb | input | 64 | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | 64 | Sum or difference, modulo 2^64 |
| carry_out | output | 1 | Carry out of bit 63 (for subtraction, 1 = no borrow) |
| ovf | output | 1 | Signed two's-complement overflow |

## Verification
The bench goes after carries that must cross every slice boundary at once, such as all-ones plus one. A block carry that picked the wrong precomputed half there would leave a run of 0xFF bytes in the result. It also drives carries that start exactly at a slice's top bit. A mistake in the two-bit carry step would corrupt only every other bit position, so both even and odd starting points are exercised. Subtraction at zero, at the most negative value and with swapped alternating patterns checks the forced carry-in and the inverted operand. A missing carry-in shows up as a result one too small and a wrong borrow sense. The overflow cases at both signed extremes catch a flag taken from the wrong carry pair.

// File: rtl/csel_pkg.sv
// Shared sizing for the conditional select adder.
// Assumes the slice width divides the data width and is even, since the
// carry step resolves two bit positions at a time.
package csel_pkg;
    parameter int DATA_W  = 64;
    parameter int SLICE_W = 8;
endpackage

// File: rtl/csel_pg.sv
// Preliminary stage of one slice: bitwise generate and propagate terms.
// Assumes nothing about the incoming carry; purely combinational.
module csel_pg #(
    parameter int N = 8
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] gen,
    output logic [N-1:0] prop
);
    // Form per-bit generate (both ones) and propagate (exactly one).
    always_comb begin
        gen  = x & y;
        prop = x ^ y;
    end
endmodule

// File: rtl/csel_pair_chain.sv
// Carry network that resolves carries two positions per step: from the
// settled carry entering position 2k it computes the carries entering
// 2k+1 and 2k+2 at once. Used inside every slice and as the block-carry
// generator across slices. Assumes N is even.
// Output c[i] is the carry into position i; c[N] is the carry out.
module csel_pair_chain #(
    parameter int N = 8
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         cin,
    output logic [N:0]   c
);
    localparam int PAIRS = N / 2;

    assign c[0] = cin;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        localparam int LO = 2 * k;
        // Resolve the next two carries from the carry entering this pair.
        always_comb begin
            c[LO+1] = gen[LO] | (prop[LO] & c[LO]);
            c[LO+2] = gen[LO+1] | (prop[LO+1] & gen[LO])
                    | (prop[LO+1] & prop[LO] & c[LO]);
        end
    end
endmodule

// File: rtl/csel_slice.sv
// One slice: prepares its result bits for an incoming carry of 0 and of 1,
// and summarises itself for the block-carry network. The carry logic
// (two pair chains) is kept apart from the sum logic (XOR with the
// propagate terms). Assumes N is even.
module csel_slice #(
    parameter int N = 8
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] sum_c0,
    output logic [N-1:0] sum_c1,
    output logic         msb_cin_c0,
    output logic         msb_cin_c1,
    output logic         grp_gen,
    output logic         grp_pass
);
    logic [N-1:0] gen, prop;
    logic [N:0]   car0, car1;

    csel_pg #(.N(N)) u_pg (
        .x(x), .y(y), .gen(gen), .prop(prop)
    );

    csel_pair_chain #(.N(N)) u_chain0 (
        .gen(gen), .prop(prop), .cin(1'b0), .c(car0)
    );

    csel_pair_chain #(.N(N)) u_chain1 (
        .gen(gen), .prop(prop), .cin(1'b1), .c(car1)
    );

    // Sum stage: both candidate results and the top-bit carry-in of each.
    always_comb begin
        sum_c0     = prop ^ car0[N-1:0];
        sum_c1     = prop ^ car1[N-1:0];
        msb_cin_c0 = car0[N-1];
        msb_cin_c1 = car1[N-1];
    end

    // Group summary: generate = carry out with cin 0; pass = carry out
    // with cin 1 (generate or full propagate), enough for the block chain.
    always_comb begin
        grp_gen  = car0[N];
        grp_pass = car1[N];
    end
endmodule

// File: rtl/csel_adder.sv
// Top of the conditional select adder/subtractor. Splits the operands into
// slices, inverts the second operand and forces a carry-in for subtraction,
// resolves block carries with a separate pair chain over slice summaries,
// then selects each slice's prepared result. Purely combinational.
// Assumes DATA_W is a multiple of SLICE_W and the slice count is even.
module csel_adder #(
    parameter int DATA_W  = csel_pkg::DATA_W,
    parameter int SLICE_W = csel_pkg::SLICE_W
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              sub_en,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              ovf
);
    localparam int NSL = DATA_W / SLICE_W;

    logic [DATA_W-1:0] opb_eff;
    logic [NSL-1:0]    blk_gen, blk_pass;
    logic [NSL-1:0]    top_cin0, top_cin1;
    logic [NSL:0]      blk_c;
    logic [SLICE_W-1:0] cand0 [NSL];
    logic [SLICE_W-1:0] cand1 [NSL];
    logic              cin_msb;

    // Condition the second operand: inverted when subtracting.
    always_comb opb_eff = opb ^ {DATA_W{sub_en}};

    for (genvar j = 0; j < NSL; j++) begin : g_slice
        csel_slice #(.N(SLICE_W)) u_slice (
            .x          (opa[j*SLICE_W +: SLICE_W]),
            .y          (opb_eff[j*SLICE_W +: SLICE_W]),
            .sum_c0     (cand0[j]),
            .sum_c1     (cand1[j]),
            .msb_cin_c0 (top_cin0[j]),
            .msb_cin_c1 (top_cin1[j]),
            .grp_gen    (blk_gen[j]),
            .grp_pass   (blk_pass[j])
        );

        // Final selection of this slice's result by its block carry.
        always_comb result[j*SLICE_W +: SLICE_W] = blk_c[j] ? cand1[j] : cand0[j];
    end

    // Block-carry generator: same pairwise carry step, across slices.
    csel_pair_chain #(.N(NSL)) u_blk (
        .gen(blk_gen), .prop(blk_pass), .cin(sub_en), .c(blk_c)
    );

    // Carry out and signed overflow from the carries around the top bit.
    always_comb begin
        cin_msb   = blk_c[NSL-1] ? top_cin1[NSL-1] : top_cin0[NSL-1];
        carry_out = blk_c[NSL];
        ovf       = cin_msb ^ blk_c[NSL];
    end
endmodule

// File: rtl/csel_adder_chk.sv
// Checker for csel_adder: compares the outputs against wide arithmetic on
// the ports. Immediate assertions, since the block has no clock.
module csel_adder_chk #(
    parameter int DATA_W = 64
) (
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic              sub_en,
    input logic [DATA_W-1:0] result,
    input logic              carry_out,
    input logic              ovf
);
    logic [DATA_W:0] ref_add, ref_sub;
    logic            sgn_bad;

    always_comb begin
        ref_add = {1'b0, opa} + {1'b0, opb};
        ref_sub = {1'b0, opa} + {1'b0, ~opb} + {{DATA_W{1'b0}}, 1'b1};
        sgn_bad = sub_en
            ? ((opa[DATA_W-1] != opb[DATA_W-1]) && (result[DATA_W-1] != opa[DATA_W-1]))
            : ((opa[DATA_W-1] == opb[DATA_W-1]) && (result[DATA_W-1] != opa[DATA_W-1]));
    end

    // R1: addition result and carry.
    always_comb if (!sub_en) begin
        assert_add_R1: assert ({carry_out, result} == ref_add)
            else $error("add mismatch");
    end

    // R2: difference modulo 2^W.
    always_comb if (sub_en) begin
        assert_sub_R2: assert (result == ref_sub[DATA_W-1:0])
            else $error("sub mismatch");
    end

    // R2: carry out means no borrow.
    always_comb if (sub_en) begin
        assert_no_borrow_R2: assert (carry_out == (opa >= opb))
            else $error("borrow sense wrong");
    end

    // R3: signed overflow flag.
    always_comb begin
        assert_ovf_R3: assert (ovf == sgn_bad)
            else $error("overflow flag wrong");
    end
endmodule

bind csel_adder csel_adder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_csel_adder.sv
// Bench for csel_adder: a vector table walked by one loop, then directed
// and random checks against wide arithmetic computed here.
module tb_csel_adder;
    localparam int W = 64;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         sub;
        logic [W-1:0] s;
        logic         c;
        logic         v;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{64'h0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0},                                      // R6
        '{64'h0, 64'h0, 1'b1, 64'h0, 1'b1, 1'b0},                                      // R6
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 1'b1, 1'b0},                     // R4
        '{64'h0000_0000_0000_00FF, 64'h1, 1'b0, 64'h0000_0000_0000_0100, 1'b0, 1'b0},   // R5
        '{64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0,
          64'h0100_0100_0100_0100, 1'b0, 1'b0},                                         // R5
        '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0,
          64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},                                         // R8
        '{64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1,
          64'hAAAA_AAAA_AAAA_AAAB, 1'b0, 1'b1},                                         // R8
        '{64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b1},   // R3
        '{64'h8000_0000_0000_0000, 64'h1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1},   // R3
        '{64'h0, 64'h1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},                     // R2
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0, 1'b1, 1'b0},   // R2
        '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0,
          64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},                                         // R1
        '{64'h0000_0000_0000_7F7F, 64'h0000_0000_0000_0081, 1'b0,
          64'h0000_0000_0000_8000, 1'b0, 1'b0}                                          // R5
    };

    logic         clk = 1'b0;
    logic [W-1:0] opa, opb, result;
    logic         sub_en, carry_out, ovf;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    csel_adder dut (
        .opa(opa), .opb(opb), .sub_en(sub_en),
        .result(result), .carry_out(carry_out), .ovf(ovf)
    );

    // Compare the three outputs with expected values.
    task automatic check(input string req, input logic [W-1:0] es,
                         input logic ec, input logic ev);
        n_chk++;
        if (result !== es || carry_out !== ec || ovf !== ev) begin
            n_bad++;
            $display("FAIL %s: got result=%h cout=%b ovf=%b, expected result=%h cout=%b ovf=%b",
                     req, result, carry_out, ovf, es, ec, ev);
        end
    endtask

    // Apply operands between clock edges and let the logic settle.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        @(negedge clk);
        opa = a; opb = b; sub_en = s;
        #1;
    endtask

    // Independent expectation from wide arithmetic.
    task automatic check_ref(input string req);
        logic [W:0] full;
        logic       v;
        full = sub_en ? ({1'b0, opa} - {1'b0, opb} + {1'b1, {W{1'b0}}})
                      : ({1'b0, opa} + {1'b0, opb});
        if (sub_en) v = (opa[W-1] != opb[W-1]) && (full[W-1] != opa[W-1]);
        else        v = (opa[W-1] == opb[W-1]) && (full[W-1] != opa[W-1]);
        check(req, full[W-1:0], full[W], v);
    endtask

    initial begin
        logic [W-1:0] held_s;
        logic         held_c, held_v;

        opa = '0; opb = '0; sub_en = 1'b0;
        // Idle state: zero inputs give zero outputs (R6).
        apply('0, '0, 1'b0);
        check("R6 idle", '0, 1'b0, 1'b0);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].a, TBL[i].b, TBL[i].sub);
            check($sformatf("table %0d (R1 R2 R3 R4 R5 R6 R8)", i), TBL[i].s, TBL[i].c, TBL[i].v);
        end

        // R5: carry born at the top bit of each slice.
        for (int j = 0; j < 8; j++) begin
            apply(64'h80 << (8 * j), 64'h80 << (8 * j), 1'b0);
            check_ref("R5 slice-top carry");
        end

        // R4: borrow through every slice when subtracting one from a slice boundary.
        for (int j = 1; j < 8; j++) begin
            apply(64'h1 << (8 * j), 64'h1, 1'b1);
            check_ref("R4 borrow ripple");
        end

        // R8: alternating patterns, swapped and both modes.
        apply(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1);
        check("R8 alt sub", 64'h5555_5555_5555_5555, 1'b1, 1'b1);

        // R1 R2: random operands in both modes.
        for (int i = 0; i < 400; i++) begin
            apply({$urandom, $urandom}, {$urandom, $urandom}, i[0]);
            check_ref(i[0] ? "R2 random sub" : "R1 random add");
        end

        // R3: random operands near the signed extremes.
        for (int i = 0; i < 40; i++) begin
            apply({1'b0, 31'h7FFF_FFFF, $urandom}, {1'b0, 31'h7FFF_FFF0, $urandom}, 1'b0);
            check_ref("R3 positive overflow");
            apply({1'b1, 63'h0} | 64'(i), {1'b0, 31'h7FFF_FFFF, $urandom}, 1'b1);
            check_ref("R3 negative overflow");
        end

        // R7: outputs unchanged over clock edges with inputs held.
        apply(64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 1'b1);
        held_s = result; held_c = carry_out; held_v = ovf;
        repeat (3) @(posedge clk);
        #1;
        check("R7 stateless", held_s, held_c, held_v);
        check_ref("R7 stateless value");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        done = 1'b1;
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule